// File: doc/BRIEF.md
# Stacked-Privilege Trap Controller

This block handles trap entry and trap return for a small core whose status state holds a stack of privilege and interrupt-enable pairs. Slot 0 of the stack is the running privilege and its global interrupt enable. Deeper slots hold the modes that were interrupted. An exception request, or an interrupt that the current privilege allows, pushes the stack and switches the core to machine mode. The same event records the cause and the faulting PC, issues a redirect to a vector that depends on the privilege left behind, and tells the memory side to drop any load reservation. A return strobe pops the stack.

The interrupt gate is combinational on the registered stack top. It covers four pending sources at two levels. Machine software and host-nonzero are machine-level sources. Supervisor software and timer (qualified by a timer enable) are supervisor-level sources. Every result is registered and appears on the outputs in the cycle after the request. The stack depth, data width, code width and vector stride are parameters.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the stack top is machine privilege (encoding 3) with enable 0. Every deeper slot is supervisor (encoding 1) with enable 0. The memory-privilege field is user (0). The cause, EPC and redirect PC are 0, and the redirect valid and reservation-clear outputs are low.
- R2: A taken trap moves each slot's pair one slot deeper and discards the deepest pair. Slot 0 becomes machine (3) with enable 0, and the memory-privilege field becomes machine (3).
- R3: A return with no trap moves each slot's pair one slot up. The deepest slot becomes user (0) with enable 1. The memory-privilege field is unchanged.
- R4: In the cycle after a taken trap, the redirect valid output is high and the redirect PC is VEC_STRIDE (default 0x40) times the slot 0 privilege held before the push. Machine gives 0xC0, supervisor 0x40 and user 0.
- R5: In that same cycle, EPC holds the trap PC input from the request cycle. For an exception, cause holds the exception code zero-extended with bit XLEN-1 clear.
- R6: For an interrupt, cause has bit XLEN-1 set and the interrupt number in its low bits: software 1, timer 5, host 8.
- R7: Machine software pending or host-nonzero is taken only when slot 0 privilege is below machine, or is machine with enable 1. In machine mode with enable 0, neither source traps.
- R8: Supervisor software pending, or timer pending together with timer enable, is taken only when slot 0 privilege is user, or is supervisor with enable 1. Timer pending without timer enable never traps.
- R9: The order of precedence runs from exception request, to machine software, to host, to supervisor software, and last to timer.
- R10: The reservation-clear output pulses high for exactly the cycle after each taken trap.
- R11: A trap and a return in the same cycle act as a trap only. A cycle with neither leaves the stack unchanged and the redirect valid output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req_i | input | 1 | Synchronous exception request |
| trap_code_i | input | CODE_W | Exception code |
| trap_pc_i | input | XLEN | PC of the trapping instruction |
| ret_i | input | 1 | Trap return strobe |
| msw_pend_i | input | 1 | Machine software interrupt pending |
| host_nz_i | input | 1 | Host-to-core mailbox is nonzero |
| ssw_pend_i | input | 1 | Supervisor software interrupt pending |
| tmr_pend_i | input | 1 | Timer interrupt pending |
| tmr_en_i | input | 1 | Timer interrupt enable |
| stack_prv_o | output | 2*DEPTH | Privilege of each slot, slot k at bits 2k+1:2k |
| stack_ie_o | output | DEPTH | Interrupt enable of each slot, slot k at bit k |
| mem_prv_o | output | 2 | Memory-access privilege field |
| cause_o | output | XLEN | Recorded trap cause |
| epc_o | output | XLEN | Recorded exception PC |
| redirect_valid_o | output | 1 | Redirect strobe |
| redirect_pc_o | output | XLEN | Trap vector address |
| resv_clr_o | output | 1 | Load reservation clear strobe |

## Verification
Every output is a register one stage from the inputs. A trap or return presented in one cycle updates the stack, cause, EPC, redirect and reservation-clear outputs at the next rising edge. Those outputs then hold until the following request, and the redirect and reservation-clear strobes last exactly that one cycle. The bench drives each request just after a falling edge and holds it across one rising edge. It samples at the next falling edge, which is the single cycle in which the strobes are visible, and it clears the inputs before the next edge.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_M = 2'd3;

   localparam int IRQ_NUM_SW    = 1;
   localparam int IRQ_NUM_TIMER = 5;
   localparam int IRQ_NUM_HOST  = 8;
endpackage

// File: rtl/tsc_priv_stack.sv
module tsc_priv_stack
   import priv_trap_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_i,
   input  logic               pop_i,
   output logic [2*DEPTH-1:0] prv_o,
   output logic [DEPTH-1:0]   ie_o,
   output logic [1:0]         mprv_o
);
   logic [1:0] prv_q [DEPTH];
   logic [1:0] prv_d [DEPTH];
   logic       ie_q  [DEPTH];
   logic       ie_d  [DEPTH];
   logic [1:0] mprv_q;

   always_comb begin
      for (int k = 0; k < DEPTH; k++) begin
         prv_d[k] = prv_q[k];
         ie_d[k]  = ie_q[k];
      end
      if (push_i) begin
         for (int k = DEPTH - 1; k >= 1; k--) begin
            prv_d[k] = prv_q[k-1];
            ie_d[k]  = ie_q[k-1];
         end
         prv_d[0] = PRV_M;
         ie_d[0]  = 1'b0;
      end else if (pop_i) begin
         for (int k = 0; k < DEPTH - 1; k++) begin
            prv_d[k] = prv_q[k+1];
            ie_d[k]  = ie_q[k+1];
         end
         prv_d[DEPTH-1] = PRV_U;
         ie_d[DEPTH-1]  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            prv_q[k] <= (k == 0) ? PRV_M : PRV_S;
            ie_q[k]  <= 1'b0;
         end
         mprv_q <= PRV_U;
      end else begin
         for (int k = 0; k < DEPTH; k++) begin
            prv_q[k] <= prv_d[k];
            ie_q[k]  <= ie_d[k];
         end
         if (push_i) mprv_q <= PRV_M;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign prv_o[2*g +: 2] = prv_q[g];
      assign ie_o[g]         = ie_q[g];
   end

   assign mprv_o = mprv_q;
endmodule

// File: rtl/tsc_irq_arbiter.sv
module tsc_irq_arbiter
   import priv_trap_pkg::*;
#(
   parameter int CODE_W = 6
) (
   input  logic [1:0]        prv_i,
   input  logic              ie_i,
   input  logic              msw_pend_i,
   input  logic              host_nz_i,
   input  logic              ssw_pend_i,
   input  logic              tmr_pend_i,
   input  logic              tmr_en_i,
   output logic              irq_valid_o,
   output logic [CODE_W-1:0] irq_num_o
);
   logic m_open, s_open;

   assign m_open = (prv_i != PRV_M) || ie_i;
   assign s_open = (prv_i == PRV_U) || ((prv_i == PRV_S) && ie_i);

   always_comb begin
      irq_valid_o = 1'b1;
      irq_num_o   = '0;
      if (m_open && msw_pend_i)
         irq_num_o = CODE_W'(IRQ_NUM_SW);
      else if (m_open && host_nz_i)
         irq_num_o = CODE_W'(IRQ_NUM_HOST);
      else if (s_open && ssw_pend_i)
         irq_num_o = CODE_W'(IRQ_NUM_SW);
      else if (s_open && tmr_pend_i && tmr_en_i)
         irq_num_o = CODE_W'(IRQ_NUM_TIMER);
      else
         irq_valid_o = 1'b0;
   end
endmodule

// File: rtl/tsc_trap_record.sv
module tsc_trap_record #(
   parameter int XLEN       = 64,
   parameter int VEC_STRIDE = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_i,
   input  logic [XLEN-1:0] cause_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [1:0]      old_prv_i,
   output logic [XLEN-1:0] cause_o,
   output logic [XLEN-1:0] epc_o,
   output logic            redirect_valid_o,
   output logic [XLEN-1:0] redirect_pc_o,
   output logic            resv_clr_o
);
   localparam bit STRIDE_POW2 = (VEC_STRIDE & (VEC_STRIDE - 1)) == 0;
   localparam int STRIDE_SH   = $clog2(VEC_STRIDE);

   logic [XLEN-1:0] vec;

   if (STRIDE_POW2) begin : g_vec_shift
      assign vec = XLEN'(old_prv_i) << STRIDE_SH;
   end else begin : g_vec_mul
      assign vec = XLEN'(old_prv_i) * XLEN'(VEC_STRIDE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_o          <= '0;
         epc_o            <= '0;
         redirect_pc_o    <= '0;
         redirect_valid_o <= 1'b0;
         resv_clr_o       <= 1'b0;
      end else begin
         redirect_valid_o <= take_i;
         resv_clr_o       <= take_i;
         if (take_i) begin
            cause_o       <= cause_i;
            epc_o         <= pc_i;
            redirect_pc_o <= vec;
         end
      end
   end
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl #(
   parameter int XLEN       = 64,
   parameter int DEPTH      = 3,
   parameter int CODE_W     = 6,
   parameter int VEC_STRIDE = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_req_i,
   input  logic [CODE_W-1:0]  trap_code_i,
   input  logic [XLEN-1:0]    trap_pc_i,
   input  logic               ret_i,
   input  logic               msw_pend_i,
   input  logic               host_nz_i,
   input  logic               ssw_pend_i,
   input  logic               tmr_pend_i,
   input  logic               tmr_en_i,
   output logic [2*DEPTH-1:0] stack_prv_o,
   output logic [DEPTH-1:0]   stack_ie_o,
   output logic [1:0]         mem_prv_o,
   output logic [XLEN-1:0]    cause_o,
   output logic [XLEN-1:0]    epc_o,
   output logic               redirect_valid_o,
   output logic [XLEN-1:0]    redirect_pc_o,
   output logic               resv_clr_o
);
   localparam int PAD_W = XLEN - 1 - CODE_W;

   if (XLEN < 32)       begin : g_bad_xlen   $error("XLEN must be at least 32"); end
   if (DEPTH < 2)       begin : g_bad_depth  $error("DEPTH must be at least 2"); end
   if (PAD_W < 1)       begin : g_bad_code   $error("CODE_W too wide for XLEN"); end
   if (VEC_STRIDE < 1)  begin : g_bad_stride $error("VEC_STRIDE must be positive"); end

   logic              irq_valid;
   logic [CODE_W-1:0] irq_num;
   logic              take;
   logic [XLEN-1:0]   cause_d;

   tsc_irq_arbiter #(.CODE_W(CODE_W)) u_arb (
      .prv_i       (stack_prv_o[1:0]),
      .ie_i        (stack_ie_o[0]),
      .msw_pend_i  (msw_pend_i),
      .host_nz_i   (host_nz_i),
      .ssw_pend_i  (ssw_pend_i),
      .tmr_pend_i  (tmr_pend_i),
      .tmr_en_i    (tmr_en_i),
      .irq_valid_o (irq_valid),
      .irq_num_o   (irq_num)
   );

   assign take    = trap_req_i || irq_valid;
   assign cause_d = trap_req_i ? {1'b0, {PAD_W{1'b0}}, trap_code_i}
                               : {1'b1, {PAD_W{1'b0}}, irq_num};

   tsc_priv_stack #(.DEPTH(DEPTH)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (take),
      .pop_i  (ret_i && !take),
      .prv_o  (stack_prv_o),
      .ie_o   (stack_ie_o),
      .mprv_o (mem_prv_o)
   );

   tsc_trap_record #(.XLEN(XLEN), .VEC_STRIDE(VEC_STRIDE)) u_rec (
      .clk              (clk),
      .rst_n            (rst_n),
      .take_i           (take),
      .cause_i          (cause_d),
      .pc_i             (trap_pc_i),
      .old_prv_i        (stack_prv_o[1:0]),
      .cause_o          (cause_o),
      .epc_o            (epc_o),
      .redirect_valid_o (redirect_valid_o),
      .redirect_pc_o    (redirect_pc_o),
      .resv_clr_o       (resv_clr_o)
   );
endmodule

// File: rtl/priv_trap_ctrl_checker.sv
module priv_trap_ctrl_checker #(
   parameter int XLEN       = 64,
   parameter int DEPTH      = 3,
   parameter int VEC_STRIDE = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trap_req_i,
   input logic [XLEN-1:0]    trap_pc_i,
   input logic               ret_i,
   input logic               msw_pend_i,
   input logic               host_nz_i,
   input logic               take_i,
   input logic [2*DEPTH-1:0] stack_prv_o,
   input logic [DEPTH-1:0]   stack_ie_o,
   input logic [1:0]         mem_prv_o,
   input logic [XLEN-1:0]    epc_o,
   input logic               redirect_valid_o,
   input logic [XLEN-1:0]    redirect_pc_o,
   input logic               resv_clr_o
);
   logic [XLEN-1:0] exp_vec;
   assign exp_vec = XLEN'(stack_prv_o[1:0]) * XLEN'(VEC_STRIDE);

   assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (stack_prv_o[1:0] == 2'd3) && !stack_ie_o[0] && (mem_prv_o == 2'd3)
                 && (stack_prv_o[3:2] == $past(stack_prv_o[1:0]))
                 && (stack_ie_o[1] == $past(stack_ie_o[0])));

   assert_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !take_i) |=> (stack_prv_o[1:0] == $past(stack_prv_o[3:2]))
                 && (stack_ie_o[0] == $past(stack_ie_o[1]))
                 && (stack_prv_o[2*DEPTH-1 -: 2] == 2'd0) && stack_ie_o[DEPTH-1]);

   assert_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> redirect_valid_o && (redirect_pc_o == $past(exp_vec)));

   assert_epc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (epc_o == $past(trap_pc_i)));

   assert_mgate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_req_i && (stack_prv_o[1:0] == 2'd3) && !stack_ie_o[0]) |=> !redirect_valid_o);

   assert_sgate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_req_i && !msw_pend_i && !host_nz_i && (stack_prv_o[1:0] == 2'd1) && !stack_ie_o[0])
         |=> !redirect_valid_o);

   assert_resv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resv_clr_o |-> (stack_prv_o[1:0] == 2'd3) && (mem_prv_o == 2'd3));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_i && !ret_i) |=> $stable(stack_prv_o) && $stable(stack_ie_o) && !redirect_valid_o);
endmodule

bind priv_trap_ctrl priv_trap_ctrl_checker #(
   .XLEN(XLEN), .DEPTH(DEPTH), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .trap_req_i       (trap_req_i),
   .trap_pc_i        (trap_pc_i),
   .ret_i            (ret_i),
   .msw_pend_i       (msw_pend_i),
   .host_nz_i        (host_nz_i),
   .take_i           (take),
   .stack_prv_o      (stack_prv_o),
   .stack_ie_o       (stack_ie_o),
   .mem_prv_o        (mem_prv_o),
   .epc_o            (epc_o),
   .redirect_valid_o (redirect_valid_o),
   .redirect_pc_o    (redirect_pc_o),
   .resv_clr_o       (resv_clr_o)
);

// File: tb/test_priv_trap_ctrl.sv
module test_priv_trap_ctrl;
   localparam int XLEN = 64, DEPTH = 3, CODE_W = 6;
   localparam logic [63:0] IRQ_BIT = 64'h8000_0000_0000_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic trap_req = 0, ret = 0, msw = 0, host = 0, ssw = 0, tp = 0, te = 0;
   logic [CODE_W-1:0] code = '0;
   logic [XLEN-1:0]   pc = '0;
   logic [2*DEPTH-1:0] stack_prv;
   logic [DEPTH-1:0]   stack_ie;
   logic [1:0]         mem_prv;
   logic [XLEN-1:0]    cause, epc, rpc;
   logic               rvalid, rclr;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [1:0]  m_prv [DEPTH];
   logic        m_ie  [DEPTH];
   logic [1:0]  m_mprv;
   logic [63:0] m_cause, m_epc, m_rpc;
   logic        m_rv, m_rc;

   priv_trap_ctrl i_priv_trap_ctrl (
      .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .trap_code_i(code),
      .trap_pc_i(pc), .ret_i(ret), .msw_pend_i(msw), .host_nz_i(host),
      .ssw_pend_i(ssw), .tmr_pend_i(tp), .tmr_en_i(te),
      .stack_prv_o(stack_prv), .stack_ie_o(stack_ie), .mem_prv_o(mem_prv),
      .cause_o(cause), .epc_o(epc), .redirect_valid_o(rvalid),
      .redirect_pc_o(rpc), .resv_clr_o(rclr)
   );

   always #10 clk = ~clk;

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete act=hung exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      for (int k = 0; k < DEPTH; k++) begin
         chk(tag, $sformatf("slot%0d prv", k), 64'(stack_prv[2*k +: 2]), 64'(m_prv[k]));
         chk(tag, $sformatf("slot%0d ie", k), 64'(stack_ie[k]), 64'(m_ie[k]));
      end
      chk(tag, "mem prv", 64'(mem_prv), 64'(m_mprv));
      chk(tag, "cause", cause, m_cause);
      chk(tag, "epc", epc, m_epc);
      chk(tag, "redirect valid", 64'(rvalid), 64'(m_rv));
      chk(tag, "redirect pc", rpc, m_rpc);
      chk(tag, "resv clear", 64'(rclr), 64'(m_rc));
   endtask

   // Expected interrupt from the eligibility and precedence requirements (R7, R8, R9)
   task automatic model_irq(output bit v, output logic [63:0] num);
      bit mo = (m_prv[0] < 2'd3) || m_ie[0];
      bit so = (m_prv[0] == 2'd0) || (m_prv[0] == 2'd1 && m_ie[0]);
      v = 1;
      if (mo && msw)            num = 64'd1;
      else if (mo && host)      num = 64'd8;
      else if (so && ssw)       num = 64'd1;
      else if (so && tp && te)  num = 64'd5;
      else begin v = 0; num = 0; end
   endtask

   task automatic step(string tag, bit t, logic [5:0] c, logic [63:0] p, bit r,
                       bit ms, bit h, bit ss, bit tpi, bit tei);
      bit iv, tk;
      logic [63:0] num;
      trap_req = t; code = c; pc = p; ret = r;
      msw = ms; host = h; ssw = ss; tp = tpi; te = tei;
      model_irq(iv, num);
      tk = t || iv;
      m_rv = tk; m_rc = tk;
      if (tk) begin
         m_rpc   = 64'(m_prv[0]) * 64'd64;
         m_epc   = p;
         m_cause = t ? 64'(c) : (IRQ_BIT | num);
         for (int k = DEPTH - 1; k >= 1; k--) begin
            m_prv[k] = m_prv[k-1]; m_ie[k] = m_ie[k-1];
         end
         m_prv[0] = 2'd3; m_ie[0] = 1'b0; m_mprv = 2'd3;
      end else if (r) begin
         for (int k = 0; k < DEPTH - 1; k++) begin
            m_prv[k] = m_prv[k+1]; m_ie[k] = m_ie[k+1];
         end
         m_prv[DEPTH-1] = 2'd0; m_ie[DEPTH-1] = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      trap_req = 0; ret = 0; msw = 0; host = 0; ssw = 0; tp = 0; te = 0;
      compare(tag);
   endtask

   task automatic t_reset();
      for (int k = 0; k < DEPTH; k++) begin
         m_prv[k] = (k == 0) ? 2'd3 : 2'd1; m_ie[k] = 0;
      end
      m_mprv = 0; m_cause = 0; m_epc = 0; m_rpc = 0; m_rv = 0; m_rc = 0;
      compare("R1");
   endtask

   task automatic t_exception();
      step("R2", 1, 6'd2, 64'h1000, 0, 0, 0, 0, 0, 0);
      chk("R4", "vector from machine", rpc, 64'hC0);
      chk("R5", "epc", epc, 64'h1000);
      chk("R5", "exception cause", cause, 64'd2);
      chk("R10", "reservation clear", 64'(rclr), 64'd1);
      step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R10", "clear pulse ends", 64'(rclr), 64'd0);
   endtask

   task automatic t_return();
      step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R3", "stack prv after two pops", 64'(stack_prv), 64'h01);
      chk("R3", "stack ie after two pops", 64'(stack_ie), 64'h6);
   endtask

   task automatic t_machine_gate();
      step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0);            // supervisor, ie 0: blocked
      step("R7", 0, 0, 64'h2000, 0, 1, 0, 0, 0, 0);     // below machine: taken
      chk("R6", "software cause", cause, IRQ_BIT | 64'd1);
      chk("R4", "vector from supervisor", rpc, 64'h40);
      step("R7", 0, 0, 0, 0, 1, 1, 0, 0, 0);            // machine, ie 0: blocked
      step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_user_irqs();
      step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0);            // timer without enable
      step("R8", 0, 0, 64'h3000, 0, 0, 0, 0, 1, 1);
      chk("R6", "timer cause", cause, IRQ_BIT | 64'd5);
      chk("R4", "vector from user", rpc, 64'h0);
      step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_priority();
      step("R9", 0, 0, 64'h10, 0, 0, 1, 1, 1, 1);
      chk("R9", "host over supervisor", cause, IRQ_BIT | 64'd8);
      step("R9", 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R9", 0, 0, 64'h20, 0, 1, 1, 0, 0, 0);
      chk("R9", "machine software over host", cause, IRQ_BIT | 64'd1);
      step("R9", 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R9", 0, 0, 64'h30, 0, 0, 0, 1, 1, 1);
      chk("R9", "supervisor software over timer", cause, IRQ_BIT | 64'd1);
      step("R9", 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R9", 1, 6'd13, 64'h40, 0, 1, 1, 1, 1, 1);
      chk("R9", "exception over interrupts", cause, 64'd13);
      step("R9", 0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_trap_and_return();
      step("R11", 1, 6'd7, 64'h5000, 1, 0, 0, 0, 0, 0);
      chk("R11", "trap wins over return", 64'(stack_prv[1:0]), 64'd3);
      step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exception();
      t_return();
      t_machine_gate();
      t_user_irqs();
      t_priority();
      t_trap_and_return();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule